// File: doc/BRIEF.md
# Eight-Input Bitonic Sorter

This block sorts a vector of eight unsigned words into ascending order every clock cycle. It has six comparator levels with a register after each one. A new vector may enter on any cycle, and each vector leaves six cycles after it enters. A valid flag travels alongside the data through the same registers.

The levels work as follows. First, pairs and then quads are sorted in alternating directions. This turns the lower four words into an ascending run and the upper four into a descending run, so the eight words together form a bitonic sequence. The last three levels then take that sequence apart with half-cleaner steps. Each step compares word i with the word a fixed distance away, and that distance halves at each level (4, 2, 1). After the last step the whole vector is in order.

Top module: `bitonic_sort8`

## Requirements
- R1: When `out_valid` is high, `out_data` is in non-decreasing order. Word i sits at bits [i*W +: W], so word 0 holds the smallest value and word 7 the largest. Comparison is unsigned.
- R2: The output words are a permutation of the input words of the same vector, and repeated values are kept with their count.
- R3: A vector sampled with `in_valid` high on clock edge t appears on `out_data` with `out_valid` high after clock edge t+5, which is the sixth edge counting edge t. It can be observed in the cycle that follows that edge.
- R4: A new vector is accepted on every clock edge. Back-to-back vectors are sorted independently and leave in the order they arrived.
- R5: While `rst` is high, every pipeline level is cleared on each clock edge. After the edge, `out_valid` is 0 and `out_data` is 0.
- R6: `out_valid` equals `in_valid` delayed by six edges, so cycles with `in_valid` low produce cycles with `out_valid` low at the matching output slot.
- R7: Sorting is correct for vectors that are all equal, already ascending, fully descending, or that hold only the two extreme values 0 and all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_data | input | 8*W | Eight unsigned words, word i at [i*W +: W] |
| out_valid | output | 1 | Output vector is valid |
| out_data | output | 8*W | Sorted words, ascending from word 0 |

## Verification
On every cycle the bound checker confirms four things. The output is in order. The sum and the XOR of the output words match those of the input vector from six cycles earlier, which confirms the words are preserved. The valid flag trails the input by exactly six edges. Reset clears the output. The sum and XOR tests alone cannot prove that each word survives exactly once, and they cannot prove that each vector comes out in its own slot. Those two points rest on the bench's sweep, which compares every output vector with an independent insertion sort over long random streams with gaps, and on directed vectors for duplicates, already-sorted and reverse-sorted input.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  // Number of comparator levels in a bitonic network of 2**lg inputs.
  function automatic int num_levels(input int lg);
    return (lg * (lg + 1)) / 2;
  endfunction

  // Linear position of level (phase p, step r) in the pipeline.
  function automatic int level_pos(input int p, input int r);
    return ((p * (p - 1)) / 2) + r;
  endfunction
endpackage

// File: rtl/bsort_cx.sv
module bsort_cx #(
  parameter int W   = 16,
  parameter bit ASC = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic swap;

  // Ascending puts the minimum on the lower index, descending the maximum.
  always_comb begin
    swap = ASC ? (a_i > b_i) : (a_i < b_i);
    lo_o = swap ? b_i : a_i;
    hi_o = swap ? a_i : b_i;
  end
endmodule

// File: rtl/bsort_level.sv
module bsort_level #(
  parameter int W    = 16,
  parameter int N    = 8,
  parameter int SPAN = 2,
  parameter int DIST = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_i,
  input  logic [N*W-1:0] dat_i,
  output logic           vld_o,
  output logic [N*W-1:0] dat_o
);
  logic [W-1:0] nxt [N];

  // One comparator per pair (i, i+DIST). The direction alternates per SPAN
  // block, so once SPAN == N the whole vector is sorted ascending.
  for (genvar i = 0; i < N; i++) begin : g_pair
    if ((i & DIST) == 0) begin : g_cx
      bsort_cx #(
        .W  (W),
        .ASC((i & SPAN) == 0)
      ) u_cx (
        .a_i (dat_i[i*W +: W]),
        .b_i (dat_i[(i+DIST)*W +: W]),
        .lo_o(nxt[i]),
        .hi_o(nxt[i+DIST])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_i;
      for (int k = 0; k < N; k++) dat_o[k*W +: W] <= nxt[k];
    end
  end
endmodule

// File: rtl/bitonic_sort8.sv
module bitonic_sort8 #(
  parameter int W     = 16,
  parameter int LOG_N = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [(1<<LOG_N)*W-1:0]   in_data,
  output logic                      out_valid,
  output logic [(1<<LOG_N)*W-1:0]   out_data
);
  localparam int N      = 1 << LOG_N;
  localparam int LEVELS = bsort_pkg::num_levels(LOG_N);

  logic [N*W-1:0] lvl_d [LEVELS+1];
  logic           lvl_v [LEVELS+1];

  assign lvl_d[0] = in_data;
  assign lvl_v[0] = in_valid;

  // Phase p builds bitonic runs of 2**p; step r halves the compare distance.
  for (genvar p = 1; p <= LOG_N; p++) begin : g_phase
    for (genvar r = 0; r < p; r++) begin : g_step
      localparam int S = bsort_pkg::level_pos(p, r);
      bsort_level #(
        .W   (W),
        .N   (N),
        .SPAN(1 << p),
        .DIST(1 << (p - 1 - r))
      ) u_lvl (
        .clk  (clk),
        .rst  (rst),
        .vld_i(lvl_v[S]),
        .dat_i(lvl_d[S]),
        .vld_o(lvl_v[S+1]),
        .dat_o(lvl_d[S+1])
      );
    end
  end

  assign out_valid = lvl_v[LEVELS];
  assign out_data  = lvl_d[LEVELS];
endmodule

// File: rtl/bitonic_sort8_chk.sv
module bitonic_sort8_chk #(
  parameter int W   = 16,
  parameter int N   = 8,
  parameter int LAT = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N*W-1:0] in_data,
  input logic           out_valid,
  input logic [N*W-1:0] out_data
);
  localparam int SW = W + $clog2(N) + 1;

  logic           vhist [LAT];
  logic [SW-1:0]  shist [LAT];
  logic [W-1:0]   xhist [LAT];
  logic [$clog2(LAT+1)-1:0] age;
  logic           full;
  logic [SW-1:0]  in_sum, out_sum;
  logic [W-1:0]   in_x, out_x;
  logic           ordered;

  always_comb begin
    in_sum = '0; out_sum = '0; in_x = '0; out_x = '0; ordered = 1'b1;
    for (int k = 0; k < N; k++) begin
      in_sum  = in_sum  + SW'(in_data[k*W +: W]);
      out_sum = out_sum + SW'(out_data[k*W +: W]);
      in_x    = in_x  ^ in_data[k*W +: W];
      out_x   = out_x ^ out_data[k*W +: W];
    end
    for (int k = 0; k + 1 < N; k++)
      if (out_data[k*W +: W] > out_data[(k+1)*W +: W]) ordered = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0;
      for (int k = 0; k < LAT; k++) begin
        vhist[k] <= 1'b0; shist[k] <= '0; xhist[k] <= '0;
      end
    end else begin
      if (!full) age <= age + 1'b1;
      vhist[0] <= in_valid; shist[0] <= in_sum; xhist[0] <= in_x;
      for (int k = 1; k < LAT; k++) begin
        vhist[k] <= vhist[k-1]; shist[k] <= shist[k-1]; xhist[k] <= xhist[k-1];
      end
    end
  end

  assign full = (age == LAT[$clog2(LAT+1)-1:0]);

  assert_sorted_R1: assert property (@(posedge clk) disable iff (rst)
    (full && out_valid) |-> ordered);

  assert_sum_kept_R2: assert property (@(posedge clk) disable iff (rst)
    full |-> (out_sum == shist[LAT-1] && out_x == xhist[LAT-1]));

  assert_valid_delay_R6: assert property (@(posedge clk) disable iff (rst)
    full |-> (out_valid == vhist[LAT-1]));

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

bind bitonic_sort8 bitonic_sort8_chk #(
  .W  (W),
  .N  (N),
  .LAT(LEVELS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/bitonic_sort8_tb.sv
module bitonic_sort8_tb;
  localparam int W   = 4;
  localparam int N   = 8;
  localparam int LAT = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic           out_valid;
  logic [N*W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  string tag = "R5";
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;  // 125 MHz

  bitonic_sort8 #(.W(W), .LOG_N(3)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    for (int i = 1; i < N; i++) begin
      t = a[i];
      for (int j = i; j > 0; j--) begin
        if (a[j-1] > t) begin a[j] = a[j-1]; a[j-1] = t; end
      end
    end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  // Reference delay line: what the output must show six edges later.
  logic [N*W-1:0] md [LAT];
  logic           mv [LAT];
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) begin md[k] <= '0; mv[k] <= 1'b0; end
    end else begin
      md[0] <= ref_sort(in_data); mv[0] <= in_valid;
      for (int k = 1; k < LAT; k++) begin md[k] <= md[k-1]; mv[k] <= mv[k-1]; end
    end
  end

  task automatic check_bit(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s valid: actual %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic check_vec(input string t, input logic [N*W-1:0] act,
                           input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s data: actual %h expected %h", t, act, exp);
    end
  endtask

  // Compare at the falling edge, then drive the next input.
  task automatic cyc(input logic v, input logic [N*W-1:0] d);
    @(negedge clk);
    check_bit({tag, " R6"}, out_valid, mv[LAT-1]);
    check_vec({tag, " R1 R2"}, out_data, md[LAT-1]);
    in_valid = v;
    in_data  = d;
  endtask

  function automatic logic [N*W-1:0] ramp(input bit up);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(up ? i * 2 : 15 - i * 2);
    return r;
  endfunction

  task automatic next_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state at the ports
    check_bit("R5 reset", out_valid, 1'b0);
    check_vec("R5 reset", out_data, '0);
    rst = 1'b0;

    // R7: directed patterns, including duplicates and extremes
    tag = "R7";
    cyc(1'b1, {N{4'h9}});
    cyc(1'b1, ramp(1'b1));
    cyc(1'b1, ramp(1'b0));
    cyc(1'b1, {4'hF, 4'h0, 4'hF, 4'h0, 4'hF, 4'h0, 4'hF, 4'h0});
    cyc(1'b1, {4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0});
    cyc(1'b1, {4'h3, 4'h3, 4'h1, 4'h1, 4'h7, 4'h7, 4'h3, 4'h1});
    cyc(1'b1, {N{4'h0}});
    cyc(1'b1, {N{4'hF}});
    for (int i = 0; i < LAT + 2; i++) cyc(1'b0, '0);

    // R4: back-to-back random vectors; R6: gaps from an LFSR bit
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      next_lfsr();
      cyc(1'b1, lfsr);
    end
    tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      next_lfsr();
      cyc(lfsr[7] ^ lfsr[19], lfsr);
    end

    // R5: reset in mid-stream flushes the pipeline
    tag = "R5 flush";
    for (int i = 0; i < 3; i++) begin next_lfsr(); cyc(1'b1, lfsr); end
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check_bit("R5 flush", out_valid, 1'b0);
    check_vec("R5 flush", out_data, '0);
    rst = 1'b0; in_valid = 1'b0; in_data = '0;
    for (int i = 0; i < LAT + 2; i++) cyc(1'b0, '0);

    // R3: a single pulse emerges exactly six edges later
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      in_valid = 1'b1; in_data = ramp(1'b0);
      for (int k = 1; k <= LAT + 3 && seen == 0; k++) begin
        @(negedge clk);
        in_valid = 1'b0;
        if (out_valid) seen = k;
      end
      checks++;
      if (seen != LAT) begin
        fails++;
        $display("FAIL R3 latency: actual %0d expected %0d", seen, LAT);
      end
      check_vec("R3 R1", out_data, ref_sort(ramp(1'b0)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule